// File: doc/BRIEF.md
# Multiplexed-Bus Burst Read Front End

This block is the device-side read front end of a memory in which the 16-bit address and the 16-bit data share one set of pins. All inputs are sampled on the rising clock edge. The chip-enable, output-enable, write-enable and address-valid strobes are active low. A 32-bit word address is loaded in two phases on the shared bus. The upper half arrives while output-enable is low and the lower half while output-enable is high, in both cases with address-valid low. Loading the lower half starts a linear burst.

When the configured initial wait count has elapsed, one word is read from a simple internal array model on every clock edge and placed on a registered data-out port. A registered output-enable tells an external tri-state buffer when to drive the shared pins. The wait count itself is kept by a small companion counter. Once output-enable has returned high during a burst, the outputs are held off until the next lower-address phase. This keeps a later upper-address phase, which also has output-enable low, from causing bus contention.

Top module: `muxbus_burst_fe`

## Requirements
- R1: On a rising edge with `ce_n`, `avd_n` and `oe_n` all low and `we_n` high, `bus_in` is stored as address bits [31:16]. This also ends any running burst.
- R2: On a rising edge with `ce_n` and `avd_n` low and `oe_n` and `we_n` high, `bus_in` becomes address bits [31:16]-completed bits [15:0] and a new burst starts. Each word read is (address[15:0] XOR address[31:16] XOR 0x5A3C).
- R3: With `cfg_wait_states` = W at the lower-address edge, the first word appears with `dout_oe` high right after the (W+1)-th rising edge following that edge. This needs `oe_n` low on that edge.
- R4: After the first word, the address goes up by one on every rising edge of the data phase (`ce_n` low, `avd_n` and `we_n` high). The word for it is driven while `oe_n` stays low.
- R5: `oe_n` high on a data-phase edge leaves `dout_oe` low but does not stop the burst: the address still advances.
- R6: After `oe_n` has been low and then high during a burst, `oe_n` low does not raise `dout_oe` again until a new lower-address phase is taken. An address phase (`avd_n` low) is never followed by `dout_oe` high.
- R7: A burst ends when `ce_n` is high on an edge or when a new address phase is started. After that no word is driven until a new burst begins.
- R8: When `cfg_burst_off` is 1 at the lower-address edge, no burst starts and `dout_oe` stays low.
- R9: An edge with `ce_n` high captures nothing, and the next cycle has `dout_oe` low.
- R10: An edge with `ce_n` low and `we_n` low captures nothing, does not advance the burst and leaves `dout_oe` low for the next cycle.
- R11: After reset, and whenever `dout_oe` is low, `dout` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable and address-half select, active low |
| we_n | input | 1 | Write enable, active low (low marks a non-read cycle) |
| avd_n | input | 1 | Address valid, active low |
| bus_in | input | 16 | Value seen on the shared address/data pins |
| cfg_burst_off | input | 1 | 1 disables synchronous burst reads |
| cfg_wait_states | input | 4 | Initial wait states before the first word |
| dout | output | 16 | Registered data word for the tri-state buffer |
| dout_oe | output | 1 | Registered drive enable for the tri-state buffer |

## Verification
A plain two-phase capture with two wait states is followed by a run of reads and a chip-enable release. This run separates correct latency counting from an early or late first word and checks the linear address step. A zero-wait burst with output-enable held high across the first data edge shows whether the burst keeps advancing while the outputs are hidden. An output-enable low–high–low sequence, a mid-burst restart, a write-enable pulse, a capture attempt while deselected and a capture with bursts disabled each separate the gate and termination rules from an implementation that would drive, restart or load when it should not.

// File: rtl/fe_pkg.sv
package fe_pkg;
    parameter int DATA_W = 16;
    parameter int ADDR_W = 2 * DATA_W;

    typedef struct packed {
        logic              active;
        logic              seen_low;
        logic              locked;
        logic [DATA_W-1:0] hi;
        logic [ADDR_W-1:0] addr;
        logic              drive;
        logic [DATA_W-1:0] dout;
    } fe_state_t;
endpackage

// File: rtl/fe_wait_cnt.sv
module fe_wait_cnt #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              step,
    output logic              done
);
    logic [WAIT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (step && (cnt_q != '0)) begin
            cnt_d = cnt_q - WAIT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/fe_array_model.sv
module fe_array_model #(
    parameter int          DATA_W = 16,
    parameter int          ADDR_W = 32,
    parameter logic [15:0] SEED   = 16'h5A3C
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    localparam int SLICES = ADDR_W / DATA_W;

    always_comb begin
        data = DATA_W'(SEED);
        for (int i = 0; i < SLICES; i++) begin
            data = data ^ addr[i*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/muxbus_burst_fe.sv
module muxbus_burst_fe
    import fe_pkg::*;
#(
    parameter int          WAIT_W = 4,
    parameter logic [15:0] SEED   = 16'h5A3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              avd_n,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              cfg_burst_off,
    input  logic [WAIT_W-1:0] cfg_wait_states,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);
    fe_state_t st_d, st_q;

    logic              sel, hi_ph, lo_ph, burst_edge, data_ph;
    logic              lat_done, lat_step;
    logic [DATA_W-1:0] mem_word;

    // decode of the strobes sampled on this edge
    assign sel        = !ce_n && we_n;
    assign hi_ph      = sel && !avd_n && !oe_n;
    assign lo_ph      = sel && !avd_n &&  oe_n;
    assign burst_edge = sel && avd_n && st_q.active;
    assign data_ph    = burst_edge && lat_done;
    assign lat_step   = burst_edge && !lat_done;

    fe_wait_cnt #(.WAIT_W(WAIT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lo_ph),
        .load_val (cfg_wait_states),
        .step     (lat_step),
        .done     (lat_done)
    );

    fe_array_model #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEED(SEED)) u_array (
        .addr (st_q.addr),
        .data (mem_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.drive = 1'b0;
        st_d.dout  = '0;

        if (ce_n) begin
            st_d.active = 1'b0;
        end

        if (hi_ph) begin
            st_d.hi     = bus_in;
            st_d.active = 1'b0;
        end

        if (lo_ph) begin
            st_d.addr     = {st_q.hi, bus_in};
            st_d.active   = !cfg_burst_off;
            st_d.seen_low = 1'b0;
            st_d.locked   = 1'b0;
        end

        // output gate: once OE was low and rose again, lock until next low phase
        if (burst_edge) begin
            if (!oe_n)              st_d.seen_low = 1'b1;
            else if (st_q.seen_low) st_d.locked   = 1'b1;
        end

        if (data_ph) begin
            st_d.addr = st_q.addr + ADDR_W'(1);
            if (!oe_n && !st_q.locked) begin
                st_d.drive = 1'b1;
                st_d.dout  = mem_word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout    = st_q.dout;
    assign dout_oe = st_q.drive;
endmodule

// File: rtl/muxbus_burst_fe_chk.sv
module muxbus_burst_fe_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              avd_n,
    input logic [DATA_W-1:0] dout,
    input logic              dout_oe
);
    p_deselect_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !dout_oe)
        else $error("R9: output enabled after deselected edge");

    p_write_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |=> !dout_oe)
        else $error("R10: output enabled after write-strobe edge");

    p_addr_phase_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !avd_n |=> !dout_oe)
        else $error("R6: output enabled after an address phase");

    p_oe_hides_r5: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> !dout_oe)
        else $error("R5: output enabled with OE high");

    p_zero_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> (dout == '0))
        else $error("R11: nonzero data while not driving");
endmodule

bind muxbus_burst_fe muxbus_burst_fe_chk #(.DATA_W(fe_pkg::DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .we_n    (we_n),
    .avd_n   (avd_n),
    .dout    (dout),
    .dout_oe (dout_oe)
);

// File: tb/muxbus_burst_fe_test.sv
`timescale 1ns/1ps
module muxbus_burst_fe_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, avd_n = 1'b1;
    logic [15:0] bus_in = '0;
    logic        cfg_burst_off = 1'b0;
    logic [3:0]  cfg_wait_states = 4'd0;
    logic [15:0] dout;
    logic        dout_oe;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    muxbus_burst_fe uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .ce_n            (ce_n),
        .oe_n            (oe_n),
        .we_n            (we_n),
        .avd_n           (avd_n),
        .bus_in          (bus_in),
        .cfg_burst_off   (cfg_burst_off),
        .cfg_wait_states (cfg_wait_states),
        .dout            (dout),
        .dout_oe         (dout_oe)
    );

    function automatic logic [15:0] word_of(input logic [15:0] hi, input logic [15:0] lo);
        return hi ^ lo ^ 16'h5A3C;
    endfunction

    // one bus cycle: drive at the falling edge, check after the next rising edge
    task automatic cyc(input logic c, input logic o, input logic w, input logic a,
                       input logic [15:0] b, input logic exp_oe,
                       input logic [15:0] exp_d, input string tag);
        ce_n = c; oe_n = o; we_n = w; avd_n = a; bus_in = b;
        @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (dout_oe !== exp_oe || dout !== (exp_oe ? exp_d : 16'h0)) begin
            n_bad++;
            $display("FAIL %s: oe=%b dout=%h expected oe=%b dout=%h",
                     tag, dout_oe, dout, exp_oe, exp_oe ? exp_d : 16'h0);
        end
    endtask

    // {ce,oe,we,avd, bus, exp_oe, exp_lo}; high half is 16'h0001; wait states = 2
    localparam logic [36:0] TBL [9] = '{
        {4'b0010, 16'h0001, 1'b0, 16'h0000},  // R1 upper half
        {4'b0110, 16'h0010, 1'b0, 16'h0000},  // R2 lower half, burst start
        {4'b0111, 16'h0000, 1'b0, 16'h0000},  // R3 wait 1
        {4'b0011, 16'h0000, 1'b0, 16'h0000},  // R3 wait 2
        {4'b0011, 16'h0000, 1'b1, 16'h0010},  // R3 first word
        {4'b0011, 16'h0000, 1'b1, 16'h0011},  // R4
        {4'b0011, 16'h0000, 1'b1, 16'h0012},  // R4
        {4'b1011, 16'h0000, 1'b0, 16'h0000},  // R7 deselect ends burst
        {4'b0011, 16'h0000, 1'b0, 16'h0000}   // R7 no word afterwards
    };

    localparam logic [15:0] H2 = 16'h0020;

    initial begin
        repeat (2) @(negedge clk);
        n_cmp++;
        if (dout_oe !== 1'b0 || dout !== 16'h0) begin
            n_bad++;
            $display("FAIL R11 reset: oe=%b dout=%h expected oe=0 dout=0000", dout_oe, dout);
        end
        rst_n = 1'b1;
        @(negedge clk);

        cfg_wait_states = 4'd2;
        for (int i = 0; i < 9; i++) begin
            cyc(TBL[i][36], TBL[i][35], TBL[i][34], TBL[i][33], TBL[i][32:17],
                TBL[i][16], word_of(16'h0001, TBL[i][15:0]), $sformatf("R1-table step %0d", i));
        end

        // R5: zero waits, OE high on first data edge, burst still advances
        cfg_wait_states = 4'd0;
        cyc(0, 0, 1, 0, H2,       0, 16'h0, "R1 upper half");
        cyc(0, 1, 1, 0, 16'h0100, 0, 16'h0, "R2 lower half");
        cyc(0, 1, 1, 1, 16'h0,    0, 16'h0, "R5 OE high hides word");
        cyc(0, 0, 1, 1, 16'h0,    1, word_of(H2, 16'h0101), "R5 burst advanced");
        // R6: OE returns high then low again -> locked out
        cyc(0, 1, 1, 1, 16'h0,    0, 16'h0, "R6 OE high");
        cyc(0, 0, 1, 1, 16'h0,    0, 16'h0, "R6 locked");
        cyc(0, 0, 1, 1, 16'h0,    0, 16'h0, "R6 still locked");
        cyc(0, 1, 1, 0, 16'h0200, 0, 16'h0, "R6 new lower half");
        cyc(0, 0, 1, 1, 16'h0,    1, word_of(H2, 16'h0200), "R6 unlocked");
        // R7: restart mid-burst with new address phase
        cyc(0, 0, 1, 1, 16'h0,    1, word_of(H2, 16'h0201), "R4 next word");
        cyc(0, 1, 1, 0, 16'h0300, 0, 16'h0, "R7 restart phase");
        cyc(0, 0, 1, 1, 16'h0,    1, word_of(H2, 16'h0300), "R7 restarted burst");
        // R10: write strobe cycle neither drives nor advances
        cyc(0, 0, 0, 1, 16'h0,    0, 16'h0, "R10 write cycle");
        cyc(0, 0, 1, 1, 16'h0,    1, word_of(H2, 16'h0301), "R10 no advance");
        // R9: capture attempt while deselected is ignored
        cyc(1, 0, 1, 0, 16'hBEEF, 0, 16'h0, "R9 deselected");
        cyc(0, 1, 1, 0, 16'h0400, 0, 16'h0, "R9 lower half");
        cyc(0, 0, 1, 1, 16'h0,    1, word_of(H2, 16'h0400), "R9 upper half kept");
        // R8: bursts disabled
        cfg_burst_off = 1'b1;
        cyc(0, 1, 1, 0, 16'h0500, 0, 16'h0, "R8 lower half");
        cyc(0, 0, 1, 1, 16'h0,    0, 16'h0, "R8 no burst");
        cyc(0, 0, 1, 1, 16'h0,    0, 16'h0, "R8 no burst");
        cfg_burst_off = 1'b0;
        cyc(0, 1, 1, 0, 16'h0600, 0, 16'h0, "R8 re-enabled");
        cyc(0, 0, 1, 1, 16'h0,    1, word_of(H2, 16'h0600), "R8 burst again");
        cyc(1, 1, 1, 1, 16'h0,    0, 16'h0, "R11 idle");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule